// File: doc/BRIEF.md
# Frame CRC Error Detector

The detector watches a stream of fixed-length frames, each made of `WORDS_PER_FRAME` 32-bit words, and checks every frame against the CRC value the system expects for it. A frame starts with `frame_start` on its first word. The expected CRC is taken together with the frame's last word. When the computed and expected values differ, the block works out what kind of fault produced the difference. It walks the frame's bit positions one per cycle and compares the syndrome with the signature of a single flipped bit and with the signature of two neighbouring flipped bits. It then writes the frame number, the bit offset and a 4-bit fault code into its error record, and pulses a valid strobe for one cycle.

An active-high error flag reports the outcome to the rest of the chip. The flag is cleared when each frame's calculation starts. It rises after a faulty frame as soon as either the error record has been written or `MIN_LOW` cycles have passed since the frame began, whichever happens first. Checking keeps going frame after frame until reset, and each new fault overwrites the earlier record.

Control sits in a five-state machine:

- **IDLE**: waits for an enabled frame start. Taking a frame start in IDLE is transition *accept*.
- **CALC**: accumulates the words. Transition *last word* leads to CHECK.
- **CHECK**: compares the result. Transition *clean* returns to IDLE; transition *mismatch* leads to SEARCH.
- **SEARCH**: runs the position search. Transition *located* leads to REPORT.
- **REPORT**: writes the record. Transition *written* returns to IDLE.

Successive frames must start only after the previous one has left SEARCH and REPORT. A frame start that arrives in any state other than IDLE is ignored.

Top module: `frame_crc_detector`

## Requirements
- R1: While reset is asserted and after it is released, `err_flag` and `rec_valid` are 0 and `rec_frame`, `rec_offset` and `rec_kind` are all zero.
- R2: A frame whose first word arrives while `enable` is low is ignored. It writes no record, does not change `err_flag`, and is not counted in the frame numbering.
- R3: The CRC has the following properties:
  - polynomial 0x04C11DB7;
  - register seeded with all ones;
  - each word fed most significant bit first;
  - no reflection and no final inversion.

  A frame whose result equals `crc_expect` (sampled with the last word) produces no record, and the flag stays low.
- R4: `err_flag` is low in the cycle after a frame's first word is accepted, and it stays low while the frame's words are being accumulated.
- R5: A fault matching a single flipped bit is recorded with `rec_kind` = 4'b0001 (bit 0 set). `rec_offset` is its position in transmission order: word i, bit b gives offset i*32 + (31 - b).
- R6: A fault matching two flipped neighbouring positions k and k+1 is recorded with `rec_kind` = 4'b0010 (bit 1 set) and `rec_offset` = k. This also holds when the pair straddles a word boundary.
- R7: A mismatch matching neither pattern is recorded with `rec_kind` = 4'b1111 and `rec_offset` = 0.
- R8: `rec_frame` holds the zero-based count of accepted frames before the faulty one, modulo 2^FIDX_W. Every write replaces all three record fields, and the fields hold their value between writes.
- R9: `rec_valid` is a one-cycle pulse, high after clock edge WORDS_PER_FRAME + FRAME_BITS − k + 2, counted from edge 0 (the edge that accepts the first word). Here k is the recorded offset. The search runs from the last position toward position 0 and tests the single-bit pattern before the pair pattern.
- R10: For a faulty frame, `err_flag` rises after edge min(MIN_LOW, WORDS_PER_FRAME + FRAME_BITS − k + 2). It never rises for a clean frame.
- R11: Once high, `err_flag` stays high until the next accepted frame start, and it is low after that edge.
- R12: Detection continues after a fault. Later frames are checked, numbered and reported in the same way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows a new frame to be accepted |
| frame_start | input | 1 | Marks the first word of a frame |
| word_valid | input | 1 | `word_data` carries a frame word this cycle |
| word_data | input | 32 | Frame word, most significant bit first in CRC order |
| crc_expect | input | 32 | Expected CRC, sampled with the frame's last word |
| err_flag | output | 1 | Error flag, active high |
| rec_valid | output | 1 | One-cycle strobe when the error record is written |
| rec_frame | output | FIDX_W (8) | Frame number of the last recorded fault |
| rec_offset | output | OFF_W (7) | Bit offset of the last recorded fault |
| rec_kind | output | 4 | Fault code: 0001 single, 0010 adjacent pair, 1111 other |

## Verification
A fault in the syndrome stepping or in the pattern priority appears on the next record as a wrong `rec_offset` or `rec_kind`. It usually also shows as a write in the wrong cycle, because the write cycle encodes how many positions were stepped. A pending-error bit that stays set, or a low-time counter that is off by one, moves the rise of `err_flag` to a different cycle within the first `MIN_LOW` cycles of a frame. A wrong seed or feed order turns clean frames into mismatches, so the error shows up within about `FRAME_BITS` cycles as an unexpected record. A frame counter that advances on ignored frames is visible on the next `rec_frame`.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    localparam int          WORD_W   = 32;
    localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
    localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CALC,
        ST_CHECK,
        ST_SEARCH,
        ST_REPORT
    } fcd_state_e;

    typedef enum logic [3:0] {
        EK_NONE   = 4'b0000,
        EK_SINGLE = 4'b0001,
        EK_DOUBLE = 4'b0010,
        EK_OTHER  = 4'b1111
    } err_kind_e;

    // Feed one 32-bit word into the CRC register, most significant bit first.
    function automatic logic [31:0] crc_shift_word(input logic [31:0] c_in,
                                                   input logic [31:0] d);
        logic [31:0] c;
        c = c_in;
        for (int i = 31; i >= 0; i--) begin
            if (c[31] ^ d[i]) begin
                c = {c[30:0], 1'b0} ^ CRC_POLY;
            end else begin
                c = {c[30:0], 1'b0};
            end
        end
        return c;
    endfunction

    // Multiply a syndrome by x modulo the generator: moves a fault one
    // position earlier in the frame.
    function automatic logic [31:0] syn_times_x(input logic [31:0] s);
        return s[31] ? ({s[30:0], 1'b0} ^ CRC_POLY) : {s[30:0], 1'b0};
    endfunction

endpackage

// File: rtl/fcd_crc_acc.sv
module fcd_crc_acc
    import fcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [WORD_W-1:0] data,
    output logic [31:0]       crc
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc <= CRC_SEED;
        end else if (load) begin
            crc <= crc_shift_word(CRC_SEED, data);
        end else if (step) begin
            crc <= crc_shift_word(crc, data);
        end
    end

endmodule

// File: rtl/fcd_locator.sv
module fcd_locator
    import fcd_pkg::*;
#(
    parameter int FRAME_BITS = 128,
    parameter int POS_W      = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [31:0]      syndrome,
    output logic             done,
    output err_kind_e        kind,
    output logic [POS_W-1:0] pos
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

    logic             busy_q;
    logic [31:0]      syn_q;
    logic [31:0]      single_q;  // signature of a fault at pos_q
    logic [31:0]      later_q;   // signature of a fault at pos_q + 1
    logic [POS_W-1:0] pos_q;

    logic hit_single;
    logic hit_pair;
    logic at_front;

    always_comb begin
        hit_single = (syn_q == single_q);
        hit_pair   = (pos_q != LAST_POS) && (syn_q == (single_q ^ later_q));
        at_front   = (pos_q == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            syn_q    <= '0;
            single_q <= '0;
            later_q  <= '0;
            pos_q    <= '0;
            done     <= 1'b0;
            kind     <= EK_NONE;
            pos      <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy_q   <= 1'b1;
                syn_q    <= syndrome;
                single_q <= CRC_POLY;
                later_q  <= '0;
                pos_q    <= LAST_POS;
            end else if (busy_q) begin
                if (hit_single) begin
                    busy_q <= 1'b0;
                    done   <= 1'b1;
                    kind   <= EK_SINGLE;
                    pos    <= pos_q;
                end else if (hit_pair) begin
                    busy_q <= 1'b0;
                    done   <= 1'b1;
                    kind   <= EK_DOUBLE;
                    pos    <= pos_q;
                end else if (at_front) begin
                    busy_q <= 1'b0;
                    done   <= 1'b1;
                    kind   <= EK_OTHER;
                    pos    <= '0;
                end else begin
                    later_q  <= single_q;
                    single_q <= syn_times_x(single_q);
                    pos_q    <= pos_q - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/fcd_flag_timer.sv
module fcd_flag_timer #(
    parameter int MIN_LOW = 32,
    parameter int CNT_W   = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_go,
    input  logic mismatch,
    input  logic report_now,
    output logic err_flag,
    output logic low_done
);

    localparam logic [CNT_W-1:0] LOW_LIMIT = CNT_W'(MIN_LOW);

    logic [CNT_W-1:0] low_cnt_q;
    logic             pending_q;
    logic             raise;

    always_comb begin
        low_done = (low_cnt_q >= LOW_LIMIT);
        raise    = pending_q && (low_done || report_now);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt_q <= '0;
        end else if (frame_go) begin
            low_cnt_q <= CNT_W'(1);
        end else if (!low_done) begin
            low_cnt_q <= low_cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
            err_flag  <= 1'b0;
        end else if (frame_go) begin
            pending_q <= 1'b0;
            err_flag  <= 1'b0;
        end else if (raise) begin
            pending_q <= 1'b0;
            err_flag  <= 1'b1;
        end else if (mismatch) begin
            pending_q <= 1'b1;
        end
    end

endmodule

// File: rtl/frame_crc_detector.sv
module frame_crc_detector
    import fcd_pkg::*;
#(
    parameter  int WORDS_PER_FRAME = 4,
    parameter  int MIN_LOW         = 32,
    parameter  int FIDX_W          = 8,
    localparam int FRAME_BITS      = WORDS_PER_FRAME * WORD_W,
    localparam int OFF_W           = $clog2(FRAME_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              frame_start,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    input  logic [31:0]       crc_expect,
    output logic              err_flag,
    output logic              rec_valid,
    output logic [FIDX_W-1:0] rec_frame,
    output logic [OFF_W-1:0]  rec_offset,
    output logic [3:0]        rec_kind
);

    localparam int CNT_W    = $clog2(MIN_LOW + 1);
    localparam bit ONE_WORD = (WORDS_PER_FRAME == 1);

    fcd_state_e state_q;
    fcd_state_e state_d;

    logic              frame_go;
    logic              in_calc;
    logic              calc_word;
    logic              last_word;
    logic              capture_exp;
    logic              report_now;
    logic              mismatch;
    logic              low_done;
    logic [31:0]       crc_now;
    logic [31:0]       exp_q;
    logic [31:0]       syndrome;
    logic [FIDX_W-1:0] frame_cnt_q;
    logic [FIDX_W-1:0] cur_frame_q;
    logic              loc_done;
    err_kind_e         loc_kind;
    logic [OFF_W-1:0]  loc_pos;

    assign frame_go   = (state_q == ST_IDLE) && enable && word_valid && frame_start;
    assign in_calc    = (state_q == ST_CALC);
    assign calc_word  = in_calc && word_valid;
    assign report_now = (state_q == ST_REPORT);
    assign syndrome   = crc_now ^ exp_q;
    assign mismatch   = (state_q == ST_CHECK) && (syndrome != '0);

    generate
        if (ONE_WORD) begin : g_one_word
            assign last_word   = 1'b0;
            assign capture_exp = frame_go;
        end else begin : g_multi_word
            localparam int WCNT_W = $clog2(WORDS_PER_FRAME) + 1;
            logic [WCNT_W-1:0] wcnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    wcnt_q <= '0;
                end else if (frame_go) begin
                    wcnt_q <= WCNT_W'(1);
                end else if (calc_word) begin
                    wcnt_q <= wcnt_q + 1'b1;
                end
            end

            assign last_word   = calc_word && (wcnt_q == WCNT_W'(WORDS_PER_FRAME - 1));
            assign capture_exp = last_word;
        end
    endgenerate

    fcd_crc_acc u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (frame_go),
        .step  (calc_word),
        .data  (word_data),
        .crc   (crc_now)
    );

    fcd_locator #(
        .FRAME_BITS (FRAME_BITS),
        .POS_W      (OFF_W)
    ) u_locator (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (mismatch),
        .syndrome (syndrome),
        .done     (loc_done),
        .kind     (loc_kind),
        .pos      (loc_pos)
    );

    fcd_flag_timer #(
        .MIN_LOW (MIN_LOW),
        .CNT_W   (CNT_W)
    ) u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_go   (frame_go),
        .mismatch   (mismatch),
        .report_now (report_now),
        .err_flag   (err_flag),
        .low_done   (low_done)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: accept, last word, clean, mismatch, located, written.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (frame_go)  state_d = ONE_WORD ? ST_CHECK : ST_CALC;
            ST_CALC:   if (last_word) state_d = ST_CHECK;
            ST_CHECK:  state_d = (syndrome != '0) ? ST_SEARCH : ST_IDLE;
            ST_SEARCH: if (loc_done)  state_d = ST_REPORT;
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs and frame bookkeeping.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_q       <= '0;
            frame_cnt_q <= '0;
            cur_frame_q <= '0;
            rec_valid   <= 1'b0;
            rec_frame   <= '0;
            rec_offset  <= '0;
            rec_kind    <= EK_NONE;
        end else begin
            rec_valid <= 1'b0;
            if (frame_go) begin
                cur_frame_q <= frame_cnt_q;
                frame_cnt_q <= frame_cnt_q + 1'b1;
            end
            if (capture_exp) begin
                exp_q <= crc_expect;
            end
            if (report_now) begin
                rec_valid  <= 1'b1;
                rec_frame  <= cur_frame_q;
                rec_offset <= loc_pos;
                rec_kind   <= loc_kind;
            end
        end
    end

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
    parameter int FIDX_W = 8,
    parameter int OFF_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              err_flag,
    input logic              rec_valid,
    input logic [FIDX_W-1:0] rec_frame,
    input logic [OFF_W-1:0]  rec_offset,
    input logic [3:0]        rec_kind,
    input logic              in_calc,
    input logic              frame_go,
    input logic              low_done
);

    p_flag_low_calc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_calc |-> !err_flag);

    p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |=> !rec_valid);

    p_kind_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> (rec_kind == 4'b0001 || rec_kind == 4'b0010 || rec_kind == 4'b1111));

    p_flag_by_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> err_flag);

    p_rise_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> (low_done || rec_valid));

    p_flag_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_go |=> !err_flag);

    p_flag_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !frame_go) |=> err_flag);

    p_record_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rec_valid |-> ($stable(rec_frame) && $stable(rec_offset) && $stable(rec_kind)));

endmodule

bind frame_crc_detector fcd_checker #(
    .FIDX_W (FIDX_W),
    .OFF_W  (OFF_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .err_flag   (err_flag),
    .rec_valid  (rec_valid),
    .rec_frame  (rec_frame),
    .rec_offset (rec_offset),
    .rec_kind   (rec_kind),
    .in_calc    (in_calc),
    .frame_go   (frame_go),
    .low_done   (low_done)
);

// File: tb/frame_crc_detector_tb_top.sv
module frame_crc_detector_tb_top;

    localparam int W       = 4;
    localparam int L       = W * 32;
    localparam int LOWMIN  = 32;
    localparam int FW      = 8;
    localparam int OW      = $clog2(L);
    localparam int GAP     = 150;
    localparam int DOG_CYC = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          frame_start = 1'b0;
    logic          word_valid = 1'b0;
    logic [31:0]   word_data = '0;
    logic [31:0]   crc_expect = '0;
    logic          err_flag;
    logic          rec_valid;
    logic [FW-1:0] rec_frame;
    logic [OW-1:0] rec_offset;
    logic [3:0]    rec_kind;

    always #10 clk = ~clk;  // 50 MHz

    frame_crc_detector #(
        .WORDS_PER_FRAME (W),
        .MIN_LOW         (LOWMIN),
        .FIDX_W          (FW)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .frame_start (frame_start),
        .word_valid  (word_valid),
        .word_data   (word_data),
        .crc_expect  (crc_expect),
        .err_flag    (err_flag),
        .rec_valid   (rec_valid),
        .rec_frame   (rec_frame),
        .rec_offset  (rec_offset),
        .rec_kind    (rec_kind)
    );

    typedef struct {
        int frame;
        int off;
        int kind;
        int cyc;
    } rec_item_t;

    rec_item_t rec_q[$];
    int        rise_q[$];
    int        cyc = 0;
    int        n_checks = 0;
    int        n_fail = 0;
    int        next_idx = 0;
    bit        finished = 0;
    logic      flag_prev = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Reference CRC, written from the requirement text.
    function automatic logic [31:0] ref_crc(input logic [31:0] c_in, input logic [31:0] d);
        logic [31:0] c;
        logic        top;
        c = c_in;
        for (int n = 0; n < 32; n++) begin
            top = c[31] ^ d[31 - n];
            c   = c << 1;
            if (top) c = c ^ 32'h04C11DB7;
        end
        return c;
    endfunction

    // Monitor: compares records and flag rises against the scoreboard.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rec_valid) begin
                if (rec_q.size() == 0) begin
                    check(0, "R9", "unexpected record write", 1, 0);
                end else begin
                    rec_item_t e;
                    e = rec_q.pop_front();
                    check(int'(rec_frame) == e.frame, "R8", "rec_frame", int'(rec_frame), e.frame);
                    check(int'(rec_offset) == e.off, "R5", "rec_offset", int'(rec_offset), e.off);
                    check(int'(rec_kind) == e.kind, (e.kind == 1) ? "R5" : (e.kind == 2) ? "R6" : "R7",
                          "rec_kind", int'(rec_kind), e.kind);
                    check(cyc == e.cyc, "R9", "record write cycle", cyc, e.cyc);
                end
            end
            if (err_flag && !flag_prev) begin
                if (rise_q.size() == 0) begin
                    check(0, "R10", "unexpected flag rise", cyc, -1);
                end else begin
                    int t;
                    t = rise_q.pop_front();
                    check(cyc == t, "R10", "flag rise cycle", cyc, t);
                end
            end
            flag_prev = err_flag;
        end
    end

    function automatic void flip(ref logic [31:0] w[W], input int p);
        w[p / 32][31 - (p % 32)] = ~w[p / 32][31 - (p % 32)];
    endfunction

    // Driver: kind 0 clean, 1 single at k, 2 pair k,k+1, 3 bits k and k+2.
    task automatic run_frame(input int seed, input int kind, input int k, input bit en_v);
        logic [31:0] w[W];
        logic [31:0] good;
        int          c0;
        good = 32'hFFFF_FFFF;
        for (int i = 0; i < W; i++) begin
            w[i] = (seed * 32'h9E3779B1) ^ (i * 32'h7F4A7C15) ^ 32'h5A5A0F0F;
            good = ref_crc(good, w[i]);
        end
        if (kind == 1) flip(w, k);
        if (kind == 2) begin flip(w, k); flip(w, k + 1); end
        if (kind == 3) begin flip(w, k); flip(w, k + 2); end
        enable     = en_v;
        crc_expect = good;
        @(negedge clk);
        word_valid  = 1'b1;
        frame_start = 1'b1;
        word_data   = w[0];
        @(negedge clk);
        c0 = cyc;
        if (en_v) begin
            check(err_flag == 1'b0, "R11", "flag after frame start", int'(err_flag), 0);
            if (kind != 0) begin
                rec_item_t e;
                int        off;
                int        t_rec;
                off   = (kind == 3) ? 0 : k;
                t_rec = W + L - off + 2;
                e.frame = next_idx % (1 << FW);
                e.off   = off;
                e.kind  = (kind == 1) ? 1 : (kind == 2) ? 2 : 15;
                e.cyc   = c0 + t_rec;
                rec_q.push_back(e);
                rise_q.push_back(c0 + ((t_rec < LOWMIN) ? t_rec : LOWMIN));
            end
            next_idx++;
        end
        frame_start = 1'b0;
        for (int i = 1; i < W; i++) begin
            word_data = w[i];
            @(negedge clk);
            if (en_v) check(err_flag == 1'b0, "R4", "flag during calculation", int'(err_flag), 0);
        end
        word_valid = 1'b0;
        repeat (GAP) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(err_flag == 1'b0, "R1", "flag in reset", int'(err_flag), 0);
        check(rec_valid == 1'b0, "R1", "valid in reset", int'(rec_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rec_frame == '0 && rec_offset == '0, "R1", "record fields after reset",
              int'(rec_frame) + int'(rec_offset), 0);
        check(rec_kind == 4'b0000, "R1", "kind after reset", int'(rec_kind), 0);

        run_frame(1, 0, 0, 1'b1);
        check(err_flag == 1'b0, "R3", "flag after clean frame", int'(err_flag), 0);

        run_frame(2, 1, 127, 1'b1);   // write before low window ends
        run_frame(3, 1, 40, 1'b1);    // low window ends first
        run_frame(4, 2, 126, 1'b1);
        run_frame(5, 2, 31, 1'b1);    // pair straddles a word boundary
        run_frame(6, 3, 10, 1'b1);    // neither pattern
        check(err_flag == 1'b1, "R11", "flag held after fault", int'(err_flag), 1);

        run_frame(7, 1, 5, 1'b0);     // disabled: ignored
        check(err_flag == 1'b1, "R2", "flag untouched by ignored frame", int'(err_flag), 1);
        check(rec_frame == FW'(5), "R2", "record untouched by ignored frame", int'(rec_frame), 5);

        run_frame(8, 0, 0, 1'b1);
        check(err_flag == 1'b0, "R12", "flag low after later clean frame", int'(err_flag), 0);
        run_frame(9, 1, 0, 1'b1);     // longest search
        run_frame(10, 1, 127, 1'b1);  // overwrite with new index

        check(rec_q.size() == 0, "R9", "records still outstanding", rec_q.size(), 0);
        check(rise_q.size() == 0, "R10", "flag rises still outstanding", rise_q.size(), 0);
        check(rec_offset == OW'(127) && rec_frame == FW'(8), "R8", "final record overwritten",
              int'(rec_frame), 8);

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (DOG_CYC) @(posedge clk);
        if (!finished) begin
            finished = 1;
            check(0, "R12", "watchdog expired", cyc, DOG_CYC);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule